// File: doc/BRIEF.md
# Line Latch with Dot-Inversion Polarity Select

This block sits between the shift-register capture stage of a column driver and its per-channel gray-level converters. It holds one full display line of six-bit gray codes, together with a polarity bit. Both are loaded when the line strobe rises. From them it works out, for every channel, which reference bank the channel uses, which reference starts the coarse segment the code falls in, and which fine step inside that segment is chosen.

Neighbouring channels always use opposite banks, so one line can drive dot inversion. The latched polarity bit decides which of the two banks the odd channels get. A per-channel drive enable stands for the output stage. It is cleared while the strobe is high, so the outputs float during that time. It is set once the strobe falls after a line has been loaded. The strobe and the polarity input are sampled on the rising edge of the block clock. Edges of the strobe are found by comparing each sample with the one before it.

Top module: `line_drive_latch`

## Requirements
- R1: A low-to-high change of the sampled strobe copies all channel codes into the line store. At any other time a change of the code inputs leaves every decoded output unchanged.
- R2: After a line has been loaded, a high-to-low change of the sampled strobe sets every `drive_en` bit to 1 from the next cycle on. The bits stay 1 while the strobe stays low.
- R3: In every cycle after a clock edge that samples the strobe high, all `drive_en` bits are 0.
- R4: `bank_sel[i]` equals the latched polarity XOR (i mod 2). Channel index 0 is the first (odd) output. `bank_sel` = 0 selects the upper bank (references 0 to 4) and 1 selects the lower bank (references 5 to 9). So with polarity 0, odd outputs use the upper bank and even outputs use the lower bank.
- R5: Codes 0x00, 0x10, 0x20 and 0x30 give `fine_step` 0 and land exactly on a bank reference.
- R6: In the upper bank, codes other than 0x3F give `ref_base` = code[5:4] and `fine_step` = code[3:0], so code 0 selects reference 0.
- R7: In the lower bank, codes other than 0x3F give `ref_base` = 9 − code[5:4] and `fine_step` = code[3:0], so code 0 selects reference 9.
- R8: Code 0x3F gives `fine_step` 0, with `ref_base` 4 in the upper bank and 5 in the lower bank.
- R9: The latched polarity changes only on a strobe rising edge. A polarity change in the middle of a line leaves `bank_sel` unchanged.
- R10: After reset, all `drive_en` bits are 0 until the first complete strobe pulse (a rise and then a fall). The stored codes and the polarity reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobe and polarity are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Line strobe; rising loads the line, falling releases the drive |
| pol_i | input | 1 | Polarity request, taken on the strobe rising edge |
| line_codes_i | input | CHANNELS*CODE_W | Captured codes; channel i at bits [i*CODE_W +: CODE_W] |
| bank_sel | output | CHANNELS | Per channel: 0 upper bank, 1 lower bank |
| ref_base | output | CHANNELS*REF_W | Per channel absolute index (0..9) of the reference that starts the segment |
| fine_step | output | CHANNELS*(CODE_W-2) | Per channel step inside the segment |
| drive_en | output | CHANNELS | Per channel drive enable; 0 means high impedance |

## Verification
The assertions watch every cycle. They check that the enables drop after a cycle in which the strobe is sampled high, and that they rise after a fall once a line has been loaded. They check that the enables stay clear before the first pulse, that the banks hold between strobe rising edges, that each channel's reference index stays inside its own bank, and that neighbouring channels always take opposite banks. Some behaviour only the bench scenarios can show, because it is checked against a reference model over whole lines. This covers the mapping from code to reference and step at the exact references and at 0x3F, that code changes between strobes are ignored, that a polarity change in the middle of a line is ignored, and that the bank assignment swaps on the next line.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    // references in each bank and in total
    localparam int BANK_REFS  = 5;
    localparam int TOTAL_REFS = 2 * BANK_REFS;
    // width of the coarse segment field at the top of a code
    localparam int SEG_W      = 2;

    // control state of the strobe sequencer
    typedef struct packed {
        logic strobe_prev;   // strobe sampled on the previous edge
        logic pol;           // polarity held for the current line
        logic loaded;        // a line has been latched since reset
        logic drive;         // output stage released
    } ctrl_state_t;

endpackage

// File: rtl/lsd_strobe_ctrl.sv
module lsd_strobe_ctrl
    import lsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic pol_i,
    output logic load_o,
    output logic pol_o,
    output logic drive_o
);

    ctrl_state_t st_d;
    ctrl_state_t st_q;
    logic        rise;
    logic        fall;

    always_comb begin
        rise = strobe_i & ~st_q.strobe_prev;
        fall = ~strobe_i & st_q.strobe_prev;
        st_d = st_q;
        st_d.strobe_prev = strobe_i;
        if (rise) begin
            st_d.pol    = pol_i;
            st_d.loaded = 1'b1;
        end
        if (strobe_i) begin
            st_d.drive = 1'b0;
        end else if (fall && st_q.loaded) begin
            st_d.drive = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o  = rise;
    assign pol_o   = st_q.pol;
    assign drive_o = st_q.drive;

endmodule

// File: rtl/lsd_line_store.sv
module lsd_line_store #(
    parameter int CHANNELS = 300,
    parameter int CODE_W   = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_i,
    input  logic [CHANNELS*CODE_W-1:0]   codes_i,
    output logic [CHANNELS*CODE_W-1:0]   codes_o
);

    localparam int LINE_W = CHANNELS * CODE_W;

    logic [LINE_W-1:0] line_d;
    logic [LINE_W-1:0] line_q;

    always_comb begin
        line_d = line_q;
        if (load_i) begin
            line_d = codes_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign codes_o = line_q;

endmodule

// File: rtl/lsd_chan_map.sv
module lsd_chan_map
    import lsd_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int REF_W  = 4,
    parameter int INDEX  = 0
) (
    input  logic [CODE_W-1:0]       code_i,
    input  logic                    pol_i,
    output logic                    bank_o,
    output logic [REF_W-1:0]        ref_o,
    output logic [CODE_W-SEG_W-1:0] step_o
);

    localparam int          STEP_W   = CODE_W - SEG_W;
    localparam logic        ODD_IDX  = 1'((INDEX % 2) == 1);
    localparam logic [CODE_W-1:0] TOP_CODE = '1;
    localparam logic [REF_W-1:0]  LAST_REL = REF_W'(BANK_REFS - 1);
    localparam logic [REF_W-1:0]  LAST_ABS = REF_W'(TOTAL_REFS - 1);

    logic [REF_W-1:0] rel;

    always_comb begin
        bank_o = pol_i ^ ODD_IDX;
        if (code_i == TOP_CODE) begin
            rel    = LAST_REL;
            step_o = '0;
        end else begin
            rel    = REF_W'(code_i[CODE_W-1 -: SEG_W]);
            step_o = code_i[STEP_W-1:0];
        end
        ref_o = bank_o ? (LAST_ABS - rel) : rel;
    end

endmodule

// File: rtl/line_drive_latch.sv
module line_drive_latch
    import lsd_pkg::*;
#(
    parameter int CHANNELS = 300,
    parameter int CODE_W   = 6,
    parameter int REF_W    = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               strobe_i,
    input  logic                               pol_i,
    input  logic [CHANNELS*CODE_W-1:0]         line_codes_i,
    output logic [CHANNELS-1:0]                bank_sel,
    output logic [CHANNELS*REF_W-1:0]          ref_base,
    output logic [CHANNELS*(CODE_W-SEG_W)-1:0] fine_step,
    output logic [CHANNELS-1:0]                drive_en
);

    localparam int STEP_W = CODE_W - SEG_W;

    logic                       load;
    logic                       pol_line;
    logic                       drive;
    logic [CHANNELS*CODE_W-1:0] held_codes;

    lsd_strobe_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .pol_i    (pol_i),
        .load_o   (load),
        .pol_o    (pol_line),
        .drive_o  (drive)
    );

    lsd_line_store #(
        .CHANNELS (CHANNELS),
        .CODE_W   (CODE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .codes_i (line_codes_i),
        .codes_o (held_codes)
    );

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        lsd_chan_map #(
            .CODE_W (CODE_W),
            .REF_W  (REF_W),
            .INDEX  (ch)
        ) u_map (
            .code_i (held_codes[ch*CODE_W +: CODE_W]),
            .pol_i  (pol_line),
            .bank_o (bank_sel[ch]),
            .ref_o  (ref_base[ch*REF_W +: REF_W]),
            .step_o (fine_step[ch*STEP_W +: STEP_W])
        );
    end

    assign drive_en = {CHANNELS{drive}};

endmodule

// File: rtl/line_drive_latch_chk.sv
module line_drive_latch_chk #(
    parameter int CHANNELS = 300,
    parameter int REF_W    = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      strobe_i,
    input logic [CHANNELS-1:0]       bank_sel,
    input logic [CHANNELS*REF_W-1:0] ref_base,
    input logic [CHANNELS-1:0]       drive_en
);

    logic prev_q;
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            prev_q <= strobe_i;
            if (strobe_i && !prev_q) begin
                seen_q <= 1'b1;
            end
        end
    end

    a_r3_float_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (drive_en == '0));

    a_r2_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_q && !strobe_i && seen_q) |=> (drive_en == '1));

    a_r10_idle_before_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (drive_en == '0));

    a_r9_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_i && !prev_q) |=> $stable(bank_sel));

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ref
        a_r4_ref_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
            bank_sel[ch] ? (ref_base[ch*REF_W +: REF_W] >= REF_W'(5) &&
                            ref_base[ch*REF_W +: REF_W] <= REF_W'(9))
                         : (ref_base[ch*REF_W +: REF_W] <= REF_W'(4)));
    end

    for (genvar ch = 0; ch + 1 < CHANNELS; ch++) begin : g_pair
        a_r4_neighbours_opposite: assert property (@(posedge clk) disable iff (!rst_n)
            bank_sel[ch] != bank_sel[ch+1]);
    end

endmodule

bind line_drive_latch line_drive_latch_chk #(
    .CHANNELS (CHANNELS),
    .REF_W    (REF_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_i),
    .bank_sel (bank_sel),
    .ref_base (ref_base),
    .drive_en (drive_en)
);

// File: tb/sim_line_drive_latch.sv
`timescale 1ns/1ps
module sim_line_drive_latch;

    localparam int CH = 300;
    localparam int CW = 6;
    localparam int RW = 4;
    localparam int SW = CW - 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strobe = 1'b0;
    logic              pol = 1'b0;
    logic [CH*CW-1:0]  codes = '0;
    logic [CH-1:0]     bank_sel;
    logic [CH*RW-1:0]  ref_base;
    logic [CH*SW-1:0]  fine_step;
    logic [CH-1:0]     drive_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural model state
    int m_code[CH];
    bit m_pol, m_prev, m_loaded, m_en;

    always #4 clk = ~clk;

    line_drive_latch #(.CHANNELS(CH), .CODE_W(CW), .REF_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .pol_i(pol),
        .line_codes_i(codes), .bank_sel(bank_sel), .ref_base(ref_base),
        .fine_step(fine_step), .drive_en(drive_en)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CH; i++) m_code[i] = 0;
            m_pol = 0; m_prev = 0; m_loaded = 0; m_en = 0;
        end else begin
            if (strobe && !m_prev) begin
                for (int i = 0; i < CH; i++) m_code[i] = int'(codes[i*CW +: CW]);
                m_pol = pol;
                m_loaded = 1;
            end
            if (strobe) m_en = 0;
            else if (m_prev && m_loaded) m_en = 1;
            m_prev = strobe;
        end
    end

    function automatic int exp_bank(int i);
        return int'(m_pol) ^ (i % 2);
    endfunction

    function automatic int exp_ref(int i);
        int c = m_code[i];
        int rel = (c == 63) ? 4 : c / 16;
        return exp_bank(i) ? 9 - rel : rel;
    endfunction

    function automatic int exp_step(int i);
        return (m_code[i] == 63) ? 0 : m_code[i] % 16;
    endfunction

    task automatic compare_model();
        int bad_en = -1, bad_bk = -1, bad_map = -1;
        for (int i = 0; i < CH; i++) begin
            if (bad_en < 0 && int'(drive_en[i]) != int'(m_en)) bad_en = i;
            if (bad_bk < 0 && int'(bank_sel[i]) != exp_bank(i)) bad_bk = i;
            if (bad_map < 0 && (int'(ref_base[i*RW +: RW]) != exp_ref(i) ||
                                int'(fine_step[i*SW +: SW]) != exp_step(i))) bad_map = i;
        end
        checks += 3;
        if (bad_en >= 0) begin
            failures++;
            $display("FAIL R2/R3/R10 enable ch%0d actual=%0d expected=%0d",
                     bad_en, drive_en[bad_en], m_en);
        end
        if (bad_bk >= 0) begin
            failures++;
            $display("FAIL R4/R9 bank ch%0d actual=%0d expected=%0d",
                     bad_bk, bank_sel[bad_bk], exp_bank(bad_bk));
        end
        if (bad_map >= 0) begin
            failures++;
            $display("FAIL R1/R6/R7 map ch%0d actual=%0d/%0d expected=%0d/%0d", bad_map,
                     ref_base[bad_map*RW +: RW], fine_step[bad_map*SW +: SW],
                     exp_ref(bad_map), exp_step(bad_map));
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare_model();
    endtask

    task automatic expect_ch(int ch, int bk, int rf, int st, string tag);
        checks++;
        if (int'(bank_sel[ch]) != bk || int'(ref_base[ch*RW +: RW]) != rf ||
            int'(fine_step[ch*SW +: SW]) != st) begin
            failures++;
            $display("FAIL %s ch%0d actual=%0d/%0d/%0d expected=%0d/%0d/%0d", tag, ch,
                     bank_sel[ch], ref_base[ch*RW +: RW], fine_step[ch*SW +: SW], bk, rf, st);
        end
    endtask

    task automatic expect_en(logic v, string tag);
        checks++;
        if (drive_en != {CH{v}}) begin
            failures++;
            $display("FAIL %s drive_en actual=%0h expected all %0d", tag, drive_en, v);
        end
    endtask

    task automatic pulse(int hi_cycles);
        strobe = 1'b1;
        repeat (hi_cycles) tick();
        expect_en(1'b0, "R3 high strobe");
        strobe = 1'b0;
        tick();
        expect_en(1'b1, "R2 after fall");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R10: reset state
        expect_en(1'b0, "R10 reset");
        expect_ch(0, 0, 0, 0, "R10 reset ch0");
        expect_ch(1, 1, 9, 0, "R10 reset ch1");

        // line 1, polarity 0
        for (int i = 0; i < CH; i++) codes[i*CW +: CW] = CW'(i % 64);
        codes[0*CW +: CW] = 6'h3F;  codes[1*CW +: CW] = 6'h3F;
        codes[2*CW +: CW] = 6'h10;  codes[3*CW +: CW] = 6'h10;
        codes[4*CW +: CW] = 6'h00;  codes[5*CW +: CW] = 6'h00;
        codes[6*CW +: CW] = 6'h25;  codes[7*CW +: CW] = 6'h25;
        codes[8*CW +: CW] = 6'h30;  codes[9*CW +: CW] = 6'h20;
        pol = 1'b0;
        tick();
        expect_en(1'b0, "R10 no pulse yet");
        pulse(3);
        expect_ch(0, 0, 4, 0, "R8 0x3F upper");
        expect_ch(1, 1, 5, 0, "R8 0x3F lower");
        expect_ch(2, 0, 1, 0, "R5 0x10 upper");
        expect_ch(3, 1, 8, 0, "R5 0x10 lower");
        expect_ch(4, 0, 0, 0, "R6 0x00 upper");
        expect_ch(5, 1, 9, 0, "R7 0x00 lower");
        expect_ch(6, 0, 2, 5, "R6 0x25 upper");
        expect_ch(7, 1, 7, 5, "R7 0x25 lower");
        expect_ch(8, 0, 3, 0, "R5 0x30 upper");
        expect_ch(9, 1, 7, 0, "R5 0x20 lower");

        // R1 and R9: mid-line changes of codes and polarity are ignored
        for (int i = 0; i < CH; i++) codes[i*CW +: CW] = CW'((i * 7 + 3) % 64);
        pol = 1'b1;
        repeat (4) tick();
        expect_ch(0, 0, 4, 0, "R1 ch0 held");
        expect_ch(7, 1, 7, 5, "R9 ch7 bank held");
        expect_en(1'b1, "R2 stays on");

        // line 2 takes polarity 1: banks swap (R4)
        pulse(1);
        expect_ch(0, 1, 9 - 0, 3, "R4 ch0 swapped");
        expect_ch(1, 0, 0, 10, "R4 ch1 swapped");

        // random lines with random polarity and pulse length
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < CH; i++) codes[i*CW +: CW] = CW'($urandom_range(0, 63));
            pol = 1'($urandom_range(0, 1));
            repeat ($urandom_range(1, 5)) tick();
            pulse($urandom_range(1, 4));
            pol = ~pol;
            repeat ($urandom_range(1, 6)) tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule